// File: doc/BRIEF.md
# Selectable-Depth I/Q Sample Packer

The packer sits between a complex baseband sample stream and a narrow byte-wide host link. Each incoming sample carries a 16-bit in-phase (I) and a 16-bit quadrature (Q) component. The block keeps only the most significant N bits of each component, where N is chosen at run time as 2, 4, 8 or 16. It packs the shortened values back to back into bytes, so a capture that can live with coarse samples uses proportionally less link bandwidth.

Both sides use a valid/ready handshake. Within a sample, I always comes before Q. Within a byte, earlier values land in the more significant bits. A depth change takes effect only at a byte boundary. A flush input pushes out a half-filled byte at the end of a capture.

Top module: `iq_sample_packer`

## Requirements
- R1: The depth code `depthSel` selects the bits kept per component: 0 keeps 2, 1 keeps 4, 2 keeps 8 and 3 keeps 16. The kept bits are always the top bits of the component, truncated with no rounding.
- R2: At depth code 3, each sample produces four bytes in this order: I[15:8], I[7:0], Q[15:8], Q[7:0].
- R3: At depth code 2, each sample produces two bytes: I[15:8], then Q[15:8].
- R4: At depth code 1, each sample produces one byte, {I[15:12], Q[15:12]}.
- R5: At depth code 0, two consecutive samples A and B produce one byte, {A.I[15:14], A.Q[15:14], B.I[15:14], B.Q[15:14]}.
- R6: `depthSel` is taken only when no partial byte is pending. A sample that completes a half-filled byte is packed at the depth already in use, whatever `depthSel` shows at that moment.
- R7: While `outValid` is high and `outReady` is low, `outByte` and `outValid` hold and `inReady` is low. Every accepted sample's bits leave exactly once, in order, under any backpressure pattern.
- R8: While `flush` is high, `inReady` is low. A flush with a half byte pending emits that byte with its low 4 bits zero. A flush with nothing pending emits no byte.
- R9: A synchronous reset discards any pending bits. In the cycle after reset, `outValid` is low and `inReady` is high.
- R10: With `outReady` held high and `flush` low, `inReady` is high whenever no byte is waiting. At depth code 1, a sample is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| depthSel | input | 2 | Depth code: 0=2, 1=4, 2=8, 3=16 bits per component |
| flush | input | 1 | Pad and emit any partial byte |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Packer can accept a sample |
| inI | input | 16 | In-phase component |
| inQ | input | 16 | Quadrature component |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Host link accepts the byte |
| outByte | output | 8 | Packed output byte |

## Verification
The properties assume that `flush` is never raised together with `inValid`, and that the host link never withdraws a byte it has not yet taken. The stimulus drives `flush` only while `inValid` is low. It changes `depthSel` only alongside a new sample or while the packer is idle. It moves `outReady` only away from the clock edge, through a fixed stall pattern that includes multi-cycle holds. The depth-boundary and flush cases are driven with a half byte deliberately left pending.

// File: rtl/iqpk_pkg.sv
package iqpk_pkg;
  localparam int COMP_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 2 * COMP_W;
  localparam int CNT_W   = $clog2(FIELD_W + 1);
  localparam int NUM_DEPTHS = 4;

  typedef enum logic [1:0] {
    DEPTH_2  = 2'd0,
    DEPTH_4  = 2'd1,
    DEPTH_8  = 2'd2,
    DEPTH_16 = 2'd3
  } depth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             takeSample;
    logic             sendByte;
    logic [CNT_W-1:0] fillPos;
    depth_e           depth;
  } pack_ctl_t;

  // bits one sample adds to the stream at a given depth
  function automatic logic [CNT_W-1:0] fieldBits(depth_e d);
    return CNT_W'(2 * (COMP_W >> (NUM_DEPTHS - 1 - int'(d))));
  endfunction
endpackage

// File: rtl/iqpk_format.sv
module iqpk_format
  import iqpk_pkg::*;
(
  input  logic [COMP_W-1:0]  inI,
  input  logic [COMP_W-1:0]  inQ,
  input  depth_e             depth,
  output logic [FIELD_W-1:0] aligned
);
  logic [FIELD_W-1:0] cand [NUM_DEPTHS];

  for (genvar d = 0; d < NUM_DEPTHS; d++) begin : g_depth
    localparam int KEEP = COMP_W >> (NUM_DEPTHS - 1 - d);
    localparam int PAD  = FIELD_W - 2 * KEEP;
    logic [FIELD_W-1:0] raw;
    // truncation: top KEEP bits of I followed by top KEEP bits of Q
    assign raw = FIELD_W'({inI[COMP_W-1 -: KEEP], inQ[COMP_W-1 -: KEEP]});
    assign cand[d] = raw << PAD;
  end

  assign aligned = cand[depth];
endmodule

// File: rtl/iqpk_ctrl.sv
module iqpk_ctrl
  import iqpk_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] depthSel,
  input  logic      flush,
  input  logic      inValid,
  input  logic      outReady,
  output logic      inReady,
  output logic      outValid,
  output pack_ctl_t ctl
);
  localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] baseCnt;
  logic [CNT_W-1:0] nextCnt;
  depth_e           heldDepth;
  depth_e           useDepth;
  logic             atBoundary;
  logic             sendByte;
  logic             takeSample;
  logic             partial;

  assign outValid   = fillCnt >= BYTE_CNT;
  assign sendByte   = outValid && outReady;
  assign baseCnt    = sendByte ? fillCnt - BYTE_CNT : fillCnt;
  assign atBoundary = baseCnt == '0;
  assign useDepth   = atBoundary ? depth_e'(depthSel) : heldDepth;
  assign inReady    = !flush && (baseCnt < BYTE_CNT);
  assign takeSample = inValid && inReady;
  assign partial    = (baseCnt & LOW_MASK) != '0;

  always_comb begin
    nextCnt = baseCnt;
    if (takeSample)
      nextCnt = baseCnt + fieldBits(useDepth);
    else if (flush && partial)
      nextCnt = (baseCnt + LOW_MASK) & ~LOW_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt   <= '0;
      heldDepth <= DEPTH_16;
    end else begin
      fillCnt <= nextCnt;
      if (atBoundary)
        heldDepth <= depth_e'(depthSel);
    end
  end

  always_comb begin
    ctl.takeSample = takeSample;
    ctl.sendByte   = sendByte;
    ctl.fillPos    = baseCnt;
    ctl.depth      = useDepth;
  end
endmodule

// File: rtl/iqpk_data.sv
module iqpk_data
  import iqpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pack_ctl_t          ctl,
  input  logic [FIELD_W-1:0] aligned,
  output logic [BYTE_W-1:0]  outByte
);
  logic [FIELD_W-1:0] stash;
  logic [FIELD_W-1:0] shifted;
  logic [FIELD_W-1:0] nextStash;

  assign shifted   = ctl.sendByte ? (stash << BYTE_W) : stash;
  assign nextStash = ctl.takeSample ? (shifted | (aligned >> ctl.fillPos)) : shifted;
  assign outByte   = stash[FIELD_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) stash <= '0;
    else     stash <= nextStash;
  end
endmodule

// File: rtl/iq_sample_packer.sv
module iq_sample_packer
  import iqpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  depthSel,
  input  logic        flush,
  input  logic        inValid,
  output logic        inReady,
  input  logic [15:0] inI,
  input  logic [15:0] inQ,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outByte
);
  pack_ctl_t          ctl;
  logic [FIELD_W-1:0] aligned;

  iqpk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .depthSel(depthSel), .flush(flush),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  iqpk_format u_format (
    .inI(inI), .inQ(inQ), .depth(ctl.depth), .aligned(aligned)
  );

  iqpk_data u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .aligned(aligned), .outByte(outByte)
  );
endmodule

// File: rtl/iqpk_checker.sv
module iqpk_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  depthSel,
  input logic        flush,
  input logic        inValid,
  input logic        inReady,
  input logic [15:0] inI,
  input logic [15:0] inQ,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outByte
);
  // R7: a stalled byte holds
  a_r7_hold_byte: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outByte));

  // R7: no sample taken while a byte is stalled
  a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |-> !inReady);

  // R8: flush closes the input
  a_r8_flush_blocks_input: assert property (@(posedge clk) disable iff (rst)
    flush |-> !inReady);

  // R9: nothing to send right after reset
  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid && inReady);

  // R10: open input whenever no byte waits
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !outValid && !flush |-> inReady);
endmodule

bind iq_sample_packer iqpk_checker u_chk (.*);

// File: tb/tb_iq_sample_packer.sv
module tb_iq_sample_packer;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  depthSel = 2'd3;
  logic        flush = 0;
  logic        inValid = 0;
  logic        inReady;
  logic [15:0] inI = 0;
  logic [15:0] inQ = 0;
  logic        outValid;
  logic        outReady = 1;
  logic [7:0]  outByte;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int stallMode = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       havePart = 0;
  logic [3:0] partBits = 0;

  always #2.5 clk = ~clk;

  iq_sample_packer dut (.*);

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) outReady <= (stallMode == 0) ? 1'b1 : ((cyc % 5) < 3);

  // stimulus: depth code, I, Q
  localparam int NV = 13;
  localparam logic [33:0] VECS [NV] = '{
    {2'd3, 16'hA5C3, 16'h1E7F}, {2'd2, 16'h8123, 16'h7FFE},
    {2'd1, 16'hF00D, 16'h3BEE}, {2'd1, 16'h4000, 16'hC000},
    {2'd0, 16'hC123, 16'h4567}, {2'd0, 16'h8000, 16'hFFFF},
    {2'd3, 16'h0001, 16'h8000}, {2'd0, 16'h7FFF, 16'h0000},
    {2'd0, 16'hBFFF, 16'h3FFF}, {2'd2, 16'hFFFF, 16'h0100},
    {2'd1, 16'h9ABC, 16'hDEF0}, {2'd0, 16'h4000, 16'h8000},
    {2'd0, 16'hC000, 16'h0000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  // reference packing built from R1..R6
  task automatic expectSample(input logic [1:0] d, input logic [15:0] i, input logic [15:0] q);
    if (havePart) begin
      push({partBits, i[15:14], q[15:14]}, "R6/R5");
      havePart = 0;
    end else begin
      case (d)
        2'd3: begin
          push(i[15:8], "R2"); push(i[7:0], "R2");
          push(q[15:8], "R2"); push(q[7:0], "R2");
        end
        2'd2: begin push(i[15:8], "R3"); push(q[15:8], "R3"); end
        2'd1: push({i[15:12], q[15:12]}, "R4");
        default: begin partBits = {i[15:14], q[15:14]}; havePart = 1; end
      endcase
    end
  endtask

  task automatic sendSample(input logic [1:0] d, input logic [15:0] i, input logic [15:0] q);
    depthSel = d; inI = i; inQ = q; inValid = 1;
    #2;
    while (!inReady) begin @(negedge clk); #2; end
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 2000 && expQ.size() != 0; n++) @(negedge clk);
    repeat (6) @(negedge clk);
    check({tag, " all bytes delivered"}, expQ.size(), 0);
  endtask

  task automatic doReset();
    rst = 1;
    expQ.delete(); tagQ.delete(); havePart = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // monitor, sampled 2 ns after the falling edge
  logic       prevStall = 0;
  logic [7:0] prevByte = 0;
  initial forever begin
    @(negedge clk); #2;
    if (rst) prevStall = 0;
    else begin
      if (prevStall) begin
        check("R7 valid held", outValid, 1);
        check("R7 byte held", outByte, prevByte);
      end
      if (outValid && !outReady) check("R7 input blocked", inReady, 0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 unexpected byte actual=%0h expected=none", outByte);
        end else begin
          logic [7:0] e; string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check({t, " byte"}, outByte, e);
        end
      end
      prevStall = outValid && !outReady;
      prevByte  = outByte;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    #2;
    check("R9 outValid after reset", outValid, 0);
    check("R9 inReady after reset", inReady, 1);
    @(negedge clk);

    // table walk, R1..R5, no backpressure
    for (int k = 0; k < NV; k++) begin
      expectSample(VECS[k][33:32], VECS[k][31:16], VECS[k][15:0]);
      sendSample(VECS[k][33:32], VECS[k][31:16], VECS[k][15:0]);
    end
    drain("R1");

    // same table under backpressure, R7
    stallMode = 1;
    for (int k = 0; k < NV; k++) begin
      expectSample(VECS[k][33:32], VECS[k][31:16], VECS[k][15:0]);
      sendSample(VECS[k][33:32], VECS[k][31:16], VECS[k][15:0]);
    end
    drain("R7");
    stallMode = 0;
    repeat (2) @(negedge clk);

    // R6: depth change while half byte pending
    expectSample(2'd0, 16'h4000, 16'hC000);
    sendSample(2'd0, 16'h4000, 16'hC000);
    expectSample(2'd3, 16'h8000, 16'h4000);
    sendSample(2'd3, 16'h8000, 16'h4000);
    expectSample(2'd3, 16'h1234, 16'h5678);
    sendSample(2'd3, 16'h1234, 16'h5678);
    drain("R6");

    // R10: full rate at depth code 1
    begin
      int c0;
      c0 = cyc;
      for (int k = 0; k < 8; k++) begin
        expectSample(2'd1, 16'(k * 16'h1111), 16'(16'hF000 - k * 16'h1000));
        sendSample(2'd1, 16'(k * 16'h1111), 16'(16'hF000 - k * 16'h1000));
      end
      check("R10 cycles for 8 samples", cyc - c0, 8);
    end
    drain("R10");

    // R8: flush with half byte pending -> 8'hD0
    expectSample(2'd0, 16'hC000, 16'h4000);
    sendSample(2'd0, 16'hC000, 16'h4000);
    flush = 1;
    push({partBits, 4'b0000}, "R8");
    havePart = 0;
    #2;
    check("R8 inReady during flush", inReady, 0);
    @(negedge clk);
    flush = 0;
    drain("R8");

    // R8: flush with nothing pending emits nothing
    flush = 1;
    @(negedge clk);
    flush = 0;
    repeat (4) @(negedge clk);
    #2;
    check("R8 no byte from empty flush", outValid, 0);
    @(negedge clk);

    // R9: reset discards a pending half byte
    expectSample(2'd0, 16'hFFFF, 16'hFFFF);
    sendSample(2'd0, 16'hFFFF, 16'hFFFF);
    doReset();
    #2;
    check("R9 outValid after mid-byte reset", outValid, 0);
    check("R9 inReady after mid-byte reset", inReady, 1);
    @(negedge clk);
    expectSample(2'd1, 16'h5A00, 16'hA500);
    sendSample(2'd1, 16'h5A00, 16'hA500);
    drain("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule